// File: doc/BRIEF.md
# Control Symbol Transmit Scheduler

This block is the last stage before line encoding in a serial link transmitter. On every clock it picks one 32-bit word (four characters, each with its own K-flag) to send: a word of packet data, a framed control symbol, a rate-compensation word or an idle word. Control symbols are built from a 19-bit body with a 5-bit CRC appended at the tail, behind one start character. Line encoding of the characters is done downstream.

Three kinds of control symbol come from the block itself. A status symbol is sent periodically from an interval timer. A multicast-event symbol is sent for every level change, rising or falling, of a toggle input. Events that arrive while one is still waiting are counted, so none is lost. A rate-compensation word is also sent periodically from a second timer. User control symbols arrive on a valid/ready request port, and packet words arrive on a valid/ready stream. While the initialisation input is high, and whenever nothing is waiting, the block sends idle.

Top module: `ctl_sym_tx_sched`

## Requirements
- R1: A control-symbol word is framed as byte 3 = 0x7C (K-flag set), bytes 2..0 = {body[18:0], crc[4:0]}, with `tx_kflag` = 4'b1000.
- R2: The CRC is computed over body bits 18 down to 0, most significant bit first, with polynomial x^5+x^4+x^2+1 (0x15) and an all-ones start value.
- R3: The idle word is four 0xBC characters with `tx_kflag` = 4'b1111. It is the reset value of the outputs, it is sent in the cycle after any cycle in which `link_init` is high, and it is sent when nothing is pending.
- R4: A packet word taken by the handshake (`pkt_valid` and `pkt_ready` high at a rising edge) appears unchanged on `tx_data` with `tx_kflag` = 0 right after that edge. Packet words keep their order.
- R5: A user control body taken by the handshake (`ctl_valid` and `ctl_ready` high at a rising edge) is sent as a control symbol right after that edge. User bodies keep their order.
- R6: Each level change of `mc_toggle` yields exactly one multicast-event symbol with body {3'b011, 16'h0}. The toggle is taken as low at reset. With nothing of higher priority waiting, the symbol appears at the second rising edge after the change.
- R7: Level changes that arrive while earlier events are still waiting are counted, up to 2^MC_CNT_W-1 outstanding, and each one is sent later.
- R8: A status symbol (body all zeros) is sent when the status timer expires. Outside initialisation, two consecutive status symbols are at least STAT_GROUPS/4 words apart. They are at most that many words plus the rate-compensation and multicast words sent between them.
- R9: The rate-compensation word is four 0x1C characters with `tx_kflag` = 4'b1111. Outside initialisation, it is sent exactly every RC_GROUPS/4 words.
- R10: Priority runs from highest to lowest: rate compensation, multicast event, status, user control symbol, packet word, idle. `ctl_ready` is low while anything above user symbols is waiting. `pkt_ready` is low while `ctl_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_init | input | 1 | High while the port is initialising; forces idle |
| pkt_valid | input | 1 | Packet word available |
| pkt_data | input | 32 | Packet word |
| pkt_ready | output | 1 | Packet word is taken at this edge |
| ctl_valid | input | 1 | User control symbol requested |
| ctl_body | input | 19 | User control symbol body |
| ctl_ready | output | 1 | Control body is taken at this edge |
| mc_toggle | input | 1 | Level change requests a multicast-event symbol |
| tx_data | output | 32 | Outgoing characters, byte 3 sent first |
| tx_kflag | output | 4 | Per-byte K-character flags |

## Verification
A packet word or user symbol is due on the output at the very edge that completes its handshake. The driver tasks check that edge's result 0.2 ns later, and they drop valid at once so that no second handshake can occur. A multicast symbol is due two edges after the toggle changes. It is checked at exactly that point, in a quiet window far from either timer. The monitor samples every word at 1 ns past the falling edge. It pops the packet and user queues in order, counts events, and measures status and rate-compensation spacing in words. The initialisation rule is checked against the value of `link_init` seen one word earlier.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BODY_W     = 19;
  localparam int CRC_W      = 5;

  localparam logic [7:0] K_IDLE = 8'hBC;
  localparam logic [7:0] K_RC   = 8'h1C;
  localparam logic [7:0] K_SOS  = 8'h7C;

  localparam logic [BODY_W-1:0] BODY_STATUS = '0;
  localparam logic [BODY_W-1:0] BODY_MCAST  = {3'b011, 16'h0000};

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_RC, SEL_MC, SEL_STAT, SEL_CTL, SEL_PKT
  } sel_e;
endpackage

// File: rtl/cs_crc5.sv
module cs_crc5 #(
  parameter int BODY_W = 19,
  parameter int CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'h15,
  parameter logic [CRC_W-1:0] INIT = 5'h1F
) (
  input  logic [BODY_W-1:0] body,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  // Serial division unrolled over the body, most significant bit first.
  always_comb begin
    acc = INIT;
    fb  = 1'b0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ body[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc = acc;
  end
endmodule

// File: rtl/cs_interval_timer.sv
module cs_interval_timer #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic served,
  output logic due
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (served)       cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign due = (cnt == LAST);

  AST_DUE_HELD: assert property (@(posedge clk) disable iff (rst)
    due && !served |=> due); // R8
  AST_SERVE_WHEN_DUE: assert property (@(posedge clk) disable iff (rst)
    served |-> due); // R9
endmodule

// File: rtl/cs_toggle_tracker.sv
module cs_toggle_tracker #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  input  logic take,
  output logic pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tog_q;
  logic [CNT_W-1:0] cnt;
  logic             chg;

  assign chg = tog_in ^ tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q <= 1'b0;
      cnt   <= '0;
    end else begin
      tog_q <= tog_in;
      case ({chg, take})
        2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign pending = (cnt != '0);

  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
    take |-> pending); // R7
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    chg && !take && (cnt != CNT_MAX) |=> pending); // R6
endmodule

// File: rtl/ctl_sym_tx_sched.sv
module ctl_sym_tx_sched
  import cs_pkg::*;
#(
  parameter int STAT_GROUPS = 1024,
  parameter int RC_GROUPS   = 5000,
  parameter int MC_CNT_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    link_init,
  input  logic                    pkt_valid,
  input  logic [8*WORD_BYTES-1:0] pkt_data,
  output logic                    pkt_ready,
  input  logic                    ctl_valid,
  input  logic [BODY_W-1:0]       ctl_body,
  output logic                    ctl_ready,
  input  logic                    mc_toggle,
  output logic [8*WORD_BYTES-1:0] tx_data,
  output logic [WORD_BYTES-1:0]   tx_kflag
);
  localparam int STAT_WORDS = STAT_GROUPS / WORD_BYTES;
  localparam int RC_WORDS   = RC_GROUPS / WORD_BYTES;
  localparam logic [8*WORD_BYTES-1:0] IDLE_W = {WORD_BYTES{K_IDLE}};
  localparam logic [8*WORD_BYTES-1:0] RC_W   = {WORD_BYTES{K_RC}};

  sel_e              sel;
  logic              rc_due, stat_due, mc_pend;
  logic [BODY_W-1:0] sym_body;
  logic [CRC_W-1:0]  sym_crc;

  cs_interval_timer #(.PERIOD(RC_WORDS)) u_rc_tmr (
    .clk(clk), .rst(rst), .served(sel == SEL_RC), .due(rc_due));

  cs_interval_timer #(.PERIOD(STAT_WORDS)) u_stat_tmr (
    .clk(clk), .rst(rst), .served(sel == SEL_STAT), .due(stat_due));

  cs_toggle_tracker #(.CNT_W(MC_CNT_W)) u_mc (
    .clk(clk), .rst(rst), .tog_in(mc_toggle), .take(sel == SEL_MC),
    .pending(mc_pend));

  // Fixed-priority pick for the word that leaves on the next edge.
  always_comb begin
    if (link_init)      sel = SEL_IDLE;
    else if (rc_due)    sel = SEL_RC;
    else if (mc_pend)   sel = SEL_MC;
    else if (stat_due)  sel = SEL_STAT;
    else if (ctl_valid) sel = SEL_CTL;
    else if (pkt_valid) sel = SEL_PKT;
    else                sel = SEL_IDLE;
  end

  assign ctl_ready = !link_init && !rc_due && !mc_pend && !stat_due;
  assign pkt_ready = ctl_ready && !ctl_valid;

  always_comb begin
    case (sel)
      SEL_STAT: sym_body = BODY_STATUS;
      SEL_MC:   sym_body = BODY_MCAST;
      default:  sym_body = ctl_body;
    endcase
  end

  cs_crc5 #(.BODY_W(BODY_W), .CRC_W(CRC_W)) u_crc (
    .body(sym_body), .crc(sym_crc));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= IDLE_W;
      tx_kflag <= '1;
    end else begin
      case (sel)
        SEL_RC: begin
          tx_data  <= RC_W;
          tx_kflag <= '1;
        end
        SEL_MC, SEL_STAT, SEL_CTL: begin
          tx_data  <= {K_SOS, sym_body, sym_crc};
          tx_kflag <= {1'b1, {(WORD_BYTES-1){1'b0}}};
        end
        SEL_PKT: begin
          tx_data  <= pkt_data;
          tx_kflag <= '0;
        end
        default: begin
          tx_data  <= IDLE_W;
          tx_kflag <= '1;
        end
      endcase
    end
  end

  AST_INIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    link_init |=> (tx_kflag == '1) && (tx_data == IDLE_W)); // R3
  AST_PKT_PASS: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_ready |=> (tx_kflag == '0) && (tx_data == $past(pkt_data))); // R4
  AST_CTL_PASS: assert property (@(posedge clk) disable iff (rst)
    ctl_valid && ctl_ready |=> (tx_kflag == 4'b1000) && (tx_data[31:5] == {K_SOS, $past(ctl_body)})); // R5
  AST_RC_FIRST: assert property (@(posedge clk) disable iff (rst)
    rc_due && !link_init |=> (tx_data == RC_W) && (tx_kflag == '1)); // R9
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pkt_ready && ctl_valid)); // R10
endmodule

// File: tb/sim_ctl_sym_tx_sched.sv
`timescale 1ns/1ps
module sim_ctl_sym_tx_sched;
  localparam int STAT_WORDS = 256;
  localparam int RC_WORDS   = 1250;
  localparam logic [31:0] IDLE_W = 32'hBCBCBCBC;
  localparam logic [31:0] RC_W   = 32'h1C1C1C1C;
  localparam logic [18:0] MC_B   = {3'b011, 16'h0000};

  logic        clk = 1'b0, rst = 1'b1, link_init = 1'b1;
  logic        pkt_valid = 1'b0, ctl_valid = 1'b0, mc_toggle = 1'b0;
  logic [31:0] pkt_data = '0;
  logic [18:0] ctl_body = '0;
  logic        pkt_ready, ctl_ready;
  logic [31:0] tx_data;
  logic [3:0]  tx_kflag;

  int n_chk = 0, n_fail = 0;
  int toggles = 0, mc_seen = 0, stat_seen = 0, rc_seen = 0;
  int widx = 0, last_stat = -1, last_rc = -1, since_stat = 0;
  bit mon_on = 1'b0, prev_init = 1'b1, done = 1'b0;
  logic [31:0] pkt_q[$];
  logic [18:0] ctl_q[$];

  always #2.5 clk = ~clk;

  ctl_sym_tx_sched u0 (
    .clk(clk), .rst(rst), .link_init(link_init),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
    .ctl_valid(ctl_valid), .ctl_body(ctl_body), .ctl_ready(ctl_ready),
    .mc_toggle(mc_toggle), .tx_data(tx_data), .tx_kflag(tx_kflag));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc(input logic [18:0] b);
    logic [4:0] c;
    logic       f;
    c = 5'h1F;
    for (int i = 18; i >= 0; i--) begin
      f = c[4] ^ b[i];
      c = {c[3:0], 1'b0};
      if (f) c = c ^ 5'h15;
    end
    return c;
  endfunction

  // Monitor: classify each output word and compare against the scoreboard.
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (prev_init)
        check(tx_kflag == 4'hF && tx_data == IDLE_W, "R3", "idle during init", tx_data, IDLE_W);
      if (ctl_valid)
        check(!pkt_ready, "R10", "pkt_ready under ctl request", pkt_ready, 0);
      case (tx_kflag)
        4'h0: begin
          if (pkt_q.size() == 0) check(0, "R4", "unexpected packet word", tx_data, 0);
          else begin
            logic [31:0] e;
            e = pkt_q.pop_front();
            check(tx_data == e, "R4", "packet order", tx_data, e);
          end
        end
        4'h8: begin
          logic [18:0] b;
          b = tx_data[23:5];
          check(tx_data[31:24] == 8'h7C, "R1", "start char", tx_data[31:24], 8'h7C);
          check(tx_data[4:0] == ref_crc(b), "R2", "symbol crc", tx_data[4:0], ref_crc(b));
          if (b == '0) begin
            stat_seen++;
            if (last_stat >= 0)
              check((widx - last_stat) >= STAT_WORDS && (widx - last_stat) <= STAT_WORDS + since_stat,
                    "R8", "status spacing", widx - last_stat, STAT_WORDS);
            last_stat  = widx;
            since_stat = 0;
          end else if (b == MC_B) begin
            mc_seen++;
            since_stat++;
          end else begin
            if (ctl_q.size() == 0) check(0, "R5", "unexpected user symbol", b, 0);
            else begin
              logic [18:0] e;
              e = ctl_q.pop_front();
              check(b == e, "R5", "user symbol order", b, e);
            end
          end
        end
        4'hF: begin
          if (tx_data == RC_W) begin
            rc_seen++;
            since_stat++;
            if (last_rc >= 0)
              check(widx - last_rc == RC_WORDS, "R9", "rate comp spacing", widx - last_rc, RC_WORDS);
            last_rc = widx;
          end else begin
            check(tx_data == IDLE_W, "R3", "idle word", tx_data, IDLE_W);
          end
        end
        default: check(0, "R1", "illegal kflag", tx_kflag, 4'h8);
      endcase
      prev_init = link_init;
      widx++;
    end
  end

  task automatic send_pkt(input logic [31:0] d);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_data  = d;
    #0.2;
    while (!pkt_ready) begin
      @(negedge clk);
      #0.2;
    end
    pkt_q.push_back(d);
    @(posedge clk);
    #0.2;
    pkt_valid = 1'b0;
    check(tx_kflag == 4'h0 && tx_data == d, "R4", "packet latency", tx_data, d);
  endtask

  task automatic send_ctl(input logic [18:0] b);
    @(negedge clk);
    ctl_valid = 1'b1;
    ctl_body  = b;
    #0.2;
    while (!ctl_ready) begin
      @(negedge clk);
      #0.2;
    end
    ctl_q.push_back(b);
    @(posedge clk);
    #0.2;
    ctl_valid = 1'b0;
    check(tx_kflag == 4'h8 && tx_data[23:5] == b, "R5", "user symbol latency", tx_data[23:5], b);
  endtask

  task automatic flip_mc();
    @(negedge clk);
    mc_toggle = ~mc_toggle;
    toggles++;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tx_kflag == 4'hF && tx_data == IDLE_W, "R3", "reset value", tx_data, IDLE_W);
    rst    = 1'b0;
    mon_on = 1'b1;
    repeat (40) @(negedge clk);
    link_init = 1'b0;
    repeat (20) @(negedge clk);

    // R6: single event in a quiet window, due two edges after the change
    mc_toggle = 1'b1;
    toggles++;
    @(posedge clk);
    @(posedge clk);
    #0.2;
    check(tx_kflag == 4'h8 && tx_data[23:5] == MC_B, "R6", "multicast latency", tx_data[23:5], MC_B);
    repeat (5) @(negedge clk);

    // R7: burst of changes on consecutive cycles, none lost
    begin
      int base;
      base = mc_seen;
      for (int i = 0; i < 5; i++) flip_mc();
      repeat (20) @(negedge clk);
      check(mc_seen - base == 5, "R7", "burst events kept", mc_seen - base, 5);
    end

    // Mixed traffic: packets, user symbols and events together (R10 priority)
    fork
      for (int i = 0; i < 300; i++) send_pkt(32'hA500_0000 + i);
      for (int i = 0; i < 40; i++) begin
        send_ctl({3'b110, 16'(i * 37 + 5)});
        repeat (i % 3) @(negedge clk);
      end
      for (int i = 0; i < 20; i++) begin
        repeat (37) @(negedge clk);
        flip_mc();
      end
    join

    repeat (4500) @(negedge clk);
    check(pkt_q.size() == 0, "R4", "packets drained", pkt_q.size(), 0);
    check(ctl_q.size() == 0, "R5", "user symbols drained", ctl_q.size(), 0);
    check(mc_seen == toggles, "R6", "one symbol per change", mc_seen, toggles);
    check(stat_seen >= 15, "R8", "status count", stat_seen, 15);
    check(rc_seen >= 3, "R9", "rate comp count", rc_seen, 3);
    finish_run();
  end
endmodule